// File: doc/BRIEF.md
# Dual-Mode Paged Memory Mapper

This block sits between a 16-bit CPU address bus and a set of physical ROMs and a large RAM. An 8-bit bank control register selects the memory model, the RAM page and the ROM page. From that register and the current CPU address, the block computes which memory is selected and the physical address inside it. Reads and writes are translated in the same cycle, so the CPU's own strobes drive the chip selects directly.

The mapper has two memory models. In ROM mode, the bottom 8 KB of the CPU space is the operating-system ROM and the next 8 KB is a paged ROM. Two 16 KB windows above that are paged RAM. In all-RAM mode, three 16 KB paged RAM windows cover the lower 48 KB. In both models the top 16 KB is common RAM at physical offset 0. Each window uses its own physical offset rule.

In ROM mode, a CPU write to the operating-system ROM does not modify memory. Instead it loads a subpage register, which chooses the 8 KB segment of an expansion ROM shown when ROM page 2 is active. Any RAM window whose physical base lies at or beyond the installed RAM size is reported as unmapped. It gets no chip select, and writes to it are inhibited.

Top module: `mem_page_mapper`

## Requirements
- R1: After a synchronous reset (active-low), the control register is 0 (ROM mode, RAM page 0, ROM page 0) and the subpage register is 0.
- R2: The control register is loaded from `ctl_wdata` on a clock edge where `ctl_we` is high. Its fields are: bit 7 selects all-RAM mode (1) or ROM mode (0), bits 6..4 are the ROM page, and bits 3..0 are the RAM page.
- R3: In ROM mode, a read at 0x0000-0x1FFF asserts `rom_cs` with `rom_sel` = 0 (operating-system ROM) and `rom_addr` = address bits 12..0.
- R4: In ROM mode, a read at 0x2000-0x3FFF asserts `rom_cs` with `rom_sel` = 1 (paged ROM) and `rom_addr` = ROM page * 0x2000 + address bits 12..0. ROM page 2 is the exception covered by R5.
- R5: In ROM mode with ROM page 2, if the subpage value is below `EXT_SEGS`, a read at 0x2000-0x3FFF gives `rom_sel` = 2 (expansion ROM) and `rom_addr` = subpage * 0x2000 + offset. Otherwise the read falls back to paged ROM page 2 with `rom_sel` = 1.
- R6: In ROM mode, a CPU write to 0x0000-0x1FFF raises `wr_inhibit`, asserts no chip select, and loads the write data into the subpage register at that clock edge. A write to 0x2000-0x3FFF is also inhibited and leaves the subpage register unchanged.
- R7: In ROM mode, the RAM window at 0x4000 maps page 0 to physical base 0x8000 and page n≥1 to 0x10000 + (n−1)*0x8000.
- R8: In ROM mode, the RAM window at 0x8000 maps page 0 to 0x4000, page 1 to 0xC000 and page n≥2 to 0x14000 + (n−2)*0x8000.
- R9: In all-RAM mode, the windows at 0x0000, 0x4000 and 0x8000 map page 0 to 0xC000, 0x8000 and 0x4000 respectively. Page n≥1 maps them to 0x10000, 0x14000 and 0x18000 respectively, each plus (n−1)*0xC000. Writes to 0x0000-0x1FFF in this mode go to RAM and do not touch the subpage register.
- R10: In both modes, accesses to 0xC000-0xFFFF assert `ram_cs` with `ram_addr` = address bits 13..0.
- R11: For a RAM window, `ram_addr` is the window base plus address bits 13..0. If the base is not below `RAM_BYTES`, an access raises `unmapped` instead of `ram_cs`, and a write there raises `wr_inhibit`. `rom_cs` and `ram_cs` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Load the bank control register |
| ctl_wdata | input | 8 | New bank control value |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data (feeds the subpage register) |
| rom_cs | output | 1 | ROM chip select (reads only) |
| rom_sel | output | 2 | ROM source: 0 operating-system, 1 paged, 2 expansion |
| rom_addr | output | SUB_W+13 | Physical address inside the selected ROM |
| ram_cs | output | 1 | RAM chip select |
| ram_addr | output | 20 | Physical RAM address |
| unmapped | output | 1 | Access hits a RAM window beyond the installed RAM |
| wr_inhibit | output | 1 | The current write must not reach any memory |

## Verification
The hardest situation to reach is the expansion ROM view, because it depends on two pieces of state set through different paths. The control register must hold ROM page 2, and the subpage register must have been loaded by a write into operating-system ROM space while ROM mode was active. The bench sets ROM page 2 and issues such writes with subpage values on both sides of `EXT_SEGS`. It also issues them from all-RAM mode and to the paged ROM window, then returns to ROM mode and reads the paged window to expose which segment the subpage register now selects. A full sweep of all 256 control values, with addresses at both edges of every window, covers every page rule and the boundary between installed and missing RAM.

// File: rtl/mpm_pkg.sv
// Package: shared types and constants for the paged memory mapper.
// Assumes a 16-bit CPU address space cut into 16 KB windows and 8 KB ROM segments.
package mpm_pkg;

    localparam int CPU_AW    = 16;
    localparam int WIN_AW    = 14;            // offset bits inside a 16 KB window
    localparam int SEG_AW    = 13;            // offset bits inside an 8 KB ROM segment
    localparam int PAGE_W    = 4;             // RAM page field width
    localparam int RPAGE_W   = 3;             // ROM page field width
    localparam int PHYS_AW   = 20;            // physical RAM address width
    localparam int PAGED_AW  = RPAGE_W + SEG_AW;

    // Bank control register; field order follows the register bit layout.
    typedef struct packed {
        logic                all_ram;         // bit 7
        logic [RPAGE_W-1:0]  rom_page;        // bits 6..4
        logic [PAGE_W-1:0]   ram_page;        // bits 3..0
    } bank_ctl_t;

    // ROM source selected for a read.
    typedef enum logic [1:0] {
        ROMSRC_OS    = 2'd0,
        ROMSRC_PAGED = 2'd1,
        ROMSRC_EXP   = 2'd2
    } rom_src_e;

    // ROM page that shows the expansion ROM.
    localparam logic [RPAGE_W-1:0] EXP_ROM_PAGE = 3'd2;

endpackage

// File: rtl/mpm_ctl_regs.sv
// Module: holds the bank control register and the ROM subpage register.
// Assumes the caller qualifies sub_we (ROM mode, write into OS ROM space).
module mpm_ctl_regs
    import mpm_pkg::*;
#(
    parameter int SUB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             sub_we,
    input  logic [SUB_W-1:0] sub_wdata,
    output bank_ctl_t        bank_q,
    output logic [SUB_W-1:0] sub_q
);

    // Bank control register: cleared by reset, loaded on ctl_we.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (ctl_we) begin
            bank_q <= bank_ctl_t'(ctl_wdata);
        end
    end

    // Subpage register: cleared by reset, loaded by qualified ROM writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else if (sub_we) begin
            sub_q <= sub_wdata;
        end
    end

endmodule

// File: rtl/mpm_ram_window.sv
// Module: computes the physical base of one 16 KB RAM window and whether it
// lies inside the installed RAM. WIN_IDX picks the window (0, 1 or 2);
// window 0 carries RAM only in all-RAM mode.
// Assumes RAM_BYTES is at most 1 MB.
module mpm_ram_window
    import mpm_pkg::*;
#(
    parameter int WIN_IDX   = 1,
    parameter int RAM_BYTES = 196608
) (
    input  logic              all_ram,
    input  logic [PAGE_W-1:0] page,
    output logic [PHYS_AW-1:0] base,
    output logic              valid
);

    localparam logic [PHYS_AW:0]   RAM_LIM   = (PHYS_AW+1)'(RAM_BYTES);
    localparam logic [PHYS_AW-1:0] WIN_STEP  = PHYS_AW'(32'h4000);
    localparam logic [PHYS_AW-1:0] ALL_BASE0 = PHYS_AW'(32'hC000 - WIN_IDX * 32'h4000);
    localparam logic [PHYS_AW-1:0] ALL_BASEN = PHYS_AW'(32'h10000 + WIN_IDX * 32'h4000);
    localparam logic [PHYS_AW-1:0] ALL_STRIDE = PHYS_AW'(32'hC000);
    localparam logic [PHYS_AW-1:0] ROM_STRIDE = PHYS_AW'(32'h8000);

    logic [PHYS_AW-1:0] pg;
    logic [PHYS_AW-1:0] all_base;
    logic [PHYS_AW-1:0] rom_base;
    logic               rom_has;

    assign pg = PHYS_AW'(page);

    // All-RAM mode base: fixed page-0 slot, then stride 48 KB per page.
    always_comb begin
        if (page == '0) begin
            all_base = ALL_BASE0;
        end else begin
            all_base = ALL_BASEN + (pg - PHYS_AW'(1)) * ALL_STRIDE;
        end
    end

    // ROM mode base: each window has its own irregular page rule.
    generate
        if (WIN_IDX == 1) begin : g_win1
            always_comb begin
                rom_has = 1'b1;
                if (page == '0) begin
                    rom_base = 2 * WIN_STEP;
                end else begin
                    rom_base = PHYS_AW'(32'h10000) + (pg - PHYS_AW'(1)) * ROM_STRIDE;
                end
            end
        end else if (WIN_IDX == 2) begin : g_win2
            always_comb begin
                rom_has = 1'b1;
                if (page == '0) begin
                    rom_base = WIN_STEP;
                end else if (page == PAGE_W'(1)) begin
                    rom_base = 3 * WIN_STEP;
                end else begin
                    rom_base = PHYS_AW'(32'h14000) + (pg - PHYS_AW'(2)) * ROM_STRIDE;
                end
            end
        end else begin : g_win0
            always_comb begin
                rom_has  = 1'b0;
                rom_base = '0;
            end
        end
    endgenerate

    // Pick the model and test the base against the installed size.
    always_comb begin
        base  = all_ram ? all_base : rom_base;
        valid = (all_ram || rom_has) && ({1'b0, base} < RAM_LIM);
    end

endmodule

// File: rtl/mpm_rom_select.sv
// Module: chooses the ROM source and physical ROM address for a ROM read.
// Assumes SUB_W >= 3 so that the paged ROM address fits in the output.
module mpm_rom_select
    import mpm_pkg::*;
#(
    parameter int EXT_SEGS = 4,
    parameter int SUB_W    = 8,
    localparam int ROM_AW  = SUB_W + SEG_AW
) (
    input  logic               os_region,
    input  logic [RPAGE_W-1:0] rom_page,
    input  logic [SUB_W-1:0]   sub_q,
    input  logic [SEG_AW-1:0]  offset,
    output rom_src_e           src,
    output logic [ROM_AW-1:0]  addr
);

    localparam logic [SUB_W:0] EXT_LIM = (SUB_W+1)'(EXT_SEGS);

    logic sub_fitted;

    assign sub_fitted = ({1'b0, sub_q} < EXT_LIM);

    // Source priority: OS ROM, then expansion segment, then paged fallback.
    always_comb begin
        if (os_region) begin
            src  = ROMSRC_OS;
            addr = ROM_AW'(offset);
        end else if (rom_page == EXP_ROM_PAGE && sub_fitted) begin
            src  = ROMSRC_EXP;
            addr = {sub_q, offset};
        end else begin
            src  = ROMSRC_PAGED;
            addr = ROM_AW'({rom_page, offset});
        end
    end

endmodule

// File: rtl/mem_page_mapper.sv
// Module: top of the dual-mode paged memory mapper. Decodes the CPU address
// against the bank control state and drives ROM/RAM selects, physical
// addresses, the unmapped flag and the write inhibit, all combinationally.
// Assumes RAM_BYTES >= 16 KB so the common window always exists.
module mem_page_mapper
    import mpm_pkg::*;
#(
    parameter int RAM_BYTES = 196608,
    parameter int EXT_SEGS  = 4,
    parameter int SUB_W     = 8,
    localparam int ROM_AW   = SUB_W + SEG_AW,
    localparam int N_WIN    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  logic [7:0]         ctl_wdata,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [7:0]         cpu_wdata,
    output logic               rom_cs,
    output logic [1:0]         rom_sel,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic               ram_cs,
    output logic [PHYS_AW-1:0] ram_addr,
    output logic               unmapped,
    output logic               wr_inhibit
);

    bank_ctl_t           bank_q;
    logic [SUB_W-1:0]    sub_q;
    logic                sub_we;
    logic                ctl_all_ram;
    logic [1:0]          region;
    logic                access;
    logic                is_rom;
    logic                is_ram;
    logic                win_ok;
    logic [PHYS_AW-1:0]  win_base;
    logic [PHYS_AW-1:0]  base_v [N_WIN];
    logic [N_WIN-1:0]    valid_v;
    rom_src_e            rsrc;
    logic [ROM_AW-1:0]   raddr;

    assign ctl_all_ram = bank_q.all_ram;
    assign region      = cpu_addr[CPU_AW-1:WIN_AW];
    assign access      = cpu_rd || cpu_wr;

    // A write into OS ROM space in ROM mode becomes a subpage load.
    assign sub_we = cpu_wr && !ctl_all_ram && (cpu_addr[CPU_AW-1:SEG_AW] == '0);

    mpm_ctl_regs #(.SUB_W(SUB_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .sub_we    (sub_we),
        .sub_wdata (cpu_wdata[SUB_W-1:0]),
        .bank_q    (bank_q),
        .sub_q     (sub_q)
    );

    // One translator per paged 16 KB window.
    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        mpm_ram_window #(.WIN_IDX(w), .RAM_BYTES(RAM_BYTES)) u_win (
            .all_ram (ctl_all_ram),
            .page    (bank_q.ram_page),
            .base    (base_v[w]),
            .valid   (valid_v[w])
        );
    end

    mpm_rom_select #(.EXT_SEGS(EXT_SEGS), .SUB_W(SUB_W)) u_rom (
        .os_region (!cpu_addr[SEG_AW]),
        .rom_page  (bank_q.rom_page),
        .sub_q     (sub_q),
        .offset    (cpu_addr[SEG_AW-1:0]),
        .src       (rsrc),
        .addr      (raddr)
    );

    // Region decode: common RAM, ROM space, or a paged RAM window.
    always_comb begin
        is_rom   = 1'b0;
        is_ram   = 1'b0;
        win_ok   = 1'b0;
        win_base = '0;
        if (region == 2'd3) begin
            is_ram = 1'b1;
            win_ok = 1'b1;
        end else if (!ctl_all_ram && region == 2'd0) begin
            is_rom = 1'b1;
        end else begin
            is_ram   = 1'b1;
            win_ok   = valid_v[region];
            win_base = base_v[region];
        end
    end

    // Output drive: selects qualified by strobes, addresses zeroed when idle.
    always_comb begin
        rom_cs     = cpu_rd && is_rom;
        rom_sel    = rom_cs ? rsrc : ROMSRC_OS;
        rom_addr   = rom_cs ? raddr : '0;
        ram_cs     = access && is_ram && win_ok;
        ram_addr   = ram_cs ? (win_base | PHYS_AW'(cpu_addr[WIN_AW-1:0])) : '0;
        unmapped   = access && is_ram && !win_ok;
        wr_inhibit = cpu_wr && !(is_ram && win_ok);
    end

endmodule

// File: rtl/mem_page_mapper_chk.sv
// Module: assertion checker for mem_page_mapper, attached by bind.
// Assumes it sees the top's ports plus the mode bit and subpage register.
module mem_page_mapper_chk
    import mpm_pkg::*;
#(
    parameter int SUB_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctl_we,
    input logic [7:0]         ctl_wdata,
    input logic [CPU_AW-1:0]  cpu_addr,
    input logic               cpu_rd,
    input logic               cpu_wr,
    input logic [7:0]         cpu_wdata,
    input logic               rom_cs,
    input logic [1:0]         rom_sel,
    input logic               ram_cs,
    input logic [PHYS_AW-1:0] ram_addr,
    input logic               unmapped,
    input logic               wr_inhibit,
    input logic               all_ram,
    input logic [SUB_W-1:0]   sub_q
);

    logic os_wr;
    assign os_wr = cpu_wr && !all_ram && (cpu_addr[15:13] == 3'b000);

    // R11: the two memories are never selected together.
    p_cs_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_cs && ram_cs));

    // R11: an unmapped access selects nothing and inhibits writes.
    p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (!ram_cs && !rom_cs && (!cpu_wr || wr_inhibit)));

    // R6: a write into OS ROM space is inhibited and selects nothing.
    p_os_write_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        os_wr |-> (wr_inhibit && !rom_cs && !ram_cs));

    // R6: such a write loads the subpage register at that edge.
    p_subpage_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        os_wr |=> (sub_q == $past(cpu_wdata[SUB_W-1:0])));

    // R10: the common window always reaches RAM at its own offset.
    p_common_ram_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && cpu_addr[15:14] == 2'b11) |->
            (ram_cs && ram_addr == PHYS_AW'(cpu_addr[13:0])));

    // R2: a control write sets the mode bit from data bit 7.
    p_ctl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (all_ram == $past(ctl_wdata[7])));

    // R1: the first cycle after reset is ROM mode with subpage 0.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !$past(ctl_we)) |-> (!all_ram && sub_q == '0));

    // R3: an OS ROM read in ROM mode reports source 0.
    p_os_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !all_ram && cpu_addr[15:13] == 3'b000) |-> (rom_cs && rom_sel == 2'd0));

endmodule

bind mem_page_mapper mem_page_mapper_chk #(.SUB_W(SUB_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .cpu_addr   (cpu_addr),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_wdata  (cpu_wdata),
    .rom_cs     (rom_cs),
    .rom_sel    (rom_sel),
    .ram_cs     (ram_cs),
    .ram_addr   (ram_addr),
    .unmapped   (unmapped),
    .wr_inhibit (wr_inhibit),
    .all_ram    (ctl_all_ram),
    .sub_q      (sub_q)
);

// File: tb/mem_page_mapper_tb.sv
module mem_page_mapper_tb;

    localparam int RAM_BYTES = 196608;
    localparam int EXT_SEGS  = 4;
    localparam int SUB_W     = 8;
    localparam int ROM_AW    = SUB_W + 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_we = 1'b0;
    logic [7:0]        ctl_wdata = '0;
    logic [15:0]       cpu_addr = '0;
    logic              cpu_rd = 1'b0;
    logic              cpu_wr = 1'b0;
    logic [7:0]        cpu_wdata = '0;
    logic              rom_cs;
    logic [1:0]        rom_sel;
    logic [ROM_AW-1:0] rom_addr;
    logic              ram_cs;
    logic [19:0]       ram_addr;
    logic              unmapped;
    logic              wr_inhibit;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    int model_ctl = 0;
    int model_sub = 0;

    always #2 clk = ~clk;

    mem_page_mapper #(.RAM_BYTES(RAM_BYTES), .EXT_SEGS(EXT_SEGS), .SUB_W(SUB_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .rom_cs(rom_cs), .rom_sel(rom_sel), .rom_addr(rom_addr),
        .ram_cs(ram_cs), .ram_addr(ram_addr), .unmapped(unmapped), .wr_inhibit(wr_inhibit)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (ctl=0x%0h addr=0x%0h)",
                     req, what, got, exp, model_ctl, cpu_addr);
        end
    endtask

    // Expected physical base of a RAM window, -1 when the window is ROM.
    function automatic int exp_base(bit allram, int win, int pg);
        if (allram) return (pg == 0) ? ('hC000 - win * 'h4000) : ('hC000 * pg + 'h4000 + win * 'h4000);
        if (win == 1) return 'h8000 * (pg + 1);
        if (win == 2) return (pg == 0) ? 'h4000 : ('h8000 * pg + 'h4000);
        return -1;
    endfunction

    // Compare all outputs for a combinational access with the model.
    task automatic probe(input int addr, input bit rd, input bit wr, input string req);
        bit allram;
        int rp, pg, win, off, base;
        bit e_rom, e_ram, e_unm;
        int e_sel, e_raddr, e_maddr;
        @(negedge clk);
        cpu_addr = 16'(addr); cpu_rd = rd; cpu_wr = wr; cpu_wdata = 8'h00;
        #1;
        allram = model_ctl[7];
        rp = (model_ctl >> 4) & 7;
        pg = model_ctl & 15;
        win = addr >> 14;
        e_rom = 0; e_ram = 0; e_unm = 0; e_sel = 0; e_raddr = 0; e_maddr = 0;
        if (win == 3) begin
            e_ram = rd | wr; e_maddr = addr & 'h3FFF;
        end else if (!allram && win == 0) begin
            e_rom = rd;
            off = addr & 'h1FFF;
            if (addr < 'h2000) begin e_sel = 0; e_raddr = off; end
            else if (rp == 2 && model_sub < EXT_SEGS) begin e_sel = 2; e_raddr = model_sub * 'h2000 + off; end
            else begin e_sel = 1; e_raddr = rp * 'h2000 + off; end
            if (!rd) begin e_sel = 0; e_raddr = 0; end
        end else begin
            base = exp_base(allram, win, pg);
            if (base < RAM_BYTES) begin e_ram = rd | wr; e_maddr = base + (addr & 'h3FFF); end
            else e_unm = rd | wr;
        end
        chk(req, "rom_cs", int'(rom_cs), int'(e_rom));
        chk(req, "rom_sel", int'(rom_sel), e_sel);
        chk(req, "rom_addr", int'(rom_addr), e_raddr);
        chk(req, "ram_cs", int'(ram_cs), int'(e_ram));
        chk(req, "ram_addr", int'(ram_addr), e_ram ? e_maddr : 0);
        chk("R11", "unmapped", int'(unmapped), int'(e_unm));
        chk(req, "wr_inhibit", int'(wr_inhibit), int'(wr && !e_ram));
        cpu_rd = 0; cpu_wr = 0;
    endtask

    task automatic set_ctl(input int v);
        @(negedge clk);
        ctl_we = 1; ctl_wdata = 8'(v);
        @(posedge clk); #1;
        ctl_we = 0;
        model_ctl = v;
    endtask

    // A clocked CPU write; checks inhibit/select during the write.
    task automatic cpu_write(input int addr, input int data);
        @(negedge clk);
        cpu_addr = 16'(addr); cpu_wr = 1; cpu_wdata = 8'(data);
        #1;
        if (!model_ctl[7] && addr < 'h4000) begin
            chk("R6", "wr_inhibit on ROM write", int'(wr_inhibit), 1);
            chk("R6", "rom_cs on ROM write", int'(rom_cs), 0);
            chk("R6", "ram_cs on ROM write", int'(ram_cs), 0);
        end
        @(posedge clk); #1;
        cpu_wr = 0;
        if (!model_ctl[7] && addr < 'h2000) model_sub = data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1;
        model_ctl = 0; model_sub = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state seen through translation
        probe('h0123, 1, 0, "R1");
        probe('h2ABC, 1, 0, "R1");
        probe('h4001, 1, 0, "R1");
        probe('h8002, 1, 0, "R1");
        probe('hC003, 1, 0, "R1");

        // R2..R11: sweep every control value over region edges
        for (int v = 0; v < 256; v++) begin
            set_ctl(v);
            probe('h0000, 1, 0, "R3");
            probe('h1FFF, 1, 0, v[7] ? "R9" : "R3");
            probe('h2000, 1, 0, v[7] ? "R9" : "R4");
            probe('h3FFF, 1, 0, v[7] ? "R9" : "R5");
            probe('h4000, 1, 0, v[7] ? "R9" : "R7");
            probe('h7FFF, 0, 1, v[7] ? "R9" : "R7");
            probe('h8000, 1, 0, v[7] ? "R9" : "R8");
            probe('hBFFF, 0, 1, v[7] ? "R9" : "R8");
            probe('hC000, 1, 0, "R10");
            probe('hFFFF, 0, 1, "R10");
            probe('h2000 + (v * 37 & 'h1FFF), 0, 0, "R2");
        end

        // R5/R6: subpage loads with values both sides of EXT_SEGS
        set_ctl('h20);
        for (int s = 0; s < 8; s++) begin
            cpu_write('h0000 + s * 'h111, s);
            probe('h2000 + s * 'h123, 1, 0, "R5");
        end
        cpu_write('h1FFF, 255);
        probe('h3FFF, 1, 0, "R5");
        cpu_write('h0005, 3);
        probe('h2345, 1, 0, "R5");
        // R6: write to paged ROM window does not load the subpage
        cpu_write('h2100, 1);
        probe('h2001, 1, 0, "R6");
        // R9: write at 0x0000 in all-RAM mode goes to RAM, subpage kept
        set_ctl('h80);
        cpu_write('h0010, 0);
        probe('h0010, 0, 1, "R9");
        set_ctl('h20);
        probe('h2777, 1, 0, "R9");
        // R1: a second reset clears both registers
        do_reset();
        probe('h2400, 1, 0, "R1");
        set_ctl('h20);
        probe('h2400, 1, 0, "R1");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule